// File: doc/BRIEF.md
# NAND flash bus cycle sequencer

This block turns single host accesses into timed bus cycles on a raw 8-bit NAND flash device. The host presents a request with an operation code (command byte, address byte, data write or data read). The block then plays out three phases: a setup phase before the strobe, a strobe-low phase and a hold phase after the strobe returns high. Each phase lasts a programmable number of clock ticks. Page-level command ordering, error correction and bulk transfer are left to the host.

Timing fields are stored as tick count minus one, and they reset to their largest values so that an unconfigured part runs at the slowest, safest speed. A parameter picks the width of the setup field: 2 bits gives 1 to 4 ticks, 3 bits gives 1 to 8 ticks. The block also holds the active-low chip enable under host control. It brings the device ready/busy line in through a two-flop synchronizer as a status bit.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset, nce_o=1, cle_o=0, ale_o=0, nwe_o=1, nre_o=1, dq_oe_o=0, busy_o=0 and ready_o=0. While busy_o=0, no strobe, latch enable or data drive is active.
- R2: With no configuration written and the base setup width (SETUP_W=2), a cycle has 4 setup ticks, 8 strobe-low ticks and 8 hold ticks.
- R3: A configuration write (cfg_we_i=1) stores setup, strobe and hold fields, each encoded as ticks minus one. Field value 0 gives 1 tick, and field value f gives f+1 ticks.
- R4: Operation code 0 (command) holds cle_o high and operation code 1 (address) holds ale_o high for every tick while busy_o=1. The other latch enable stays low, and cle_o and ale_o are never both high.
- R5: For operation codes 0, 1 and 2 (data write), dq_oe_o=1 and dq_o equals the request data from the first setup tick through the last hold tick. nwe_o is low only in the strobe phase, and nre_o stays high.
- R6: Operation code 3 (data read) drives nre_o low in the strobe phase and leaves nwe_o high and dq_oe_o low. The byte on dq_i in the last strobe tick appears on rdata_o at the rising edge of nre_o, and rdata_valid_o pulses for one cycle.
- R7: A write with ce_we_i=1 sets nce_o to ce_off_i on the next clock. Without such a write, nce_o does not change.
- R8: ready_o follows rnb_i (1 means ready, 0 means busy) two clock edges later.
- R9: A request (req_i=1) is accepted only while busy_o=0, and busy_o rises on the next clock. A request pulse during a cycle is dropped.
- R10: The three timing fields are captured when a request is accepted. A configuration write during a cycle changes only later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Timing configuration write strobe |
| cfg_setup_i | input | SETUP_W | Setup ticks minus one |
| cfg_strobe_i | input | PULSE_W | Strobe-low ticks minus one |
| cfg_hold_i | input | PULSE_W | Hold ticks minus one |
| ce_we_i | input | 1 | Chip enable register write strobe |
| ce_off_i | input | 1 | Chip enable value (1 deselects) |
| req_i | input | 1 | Access request |
| req_op_i | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_data_i | input | DATA_W | Byte to write |
| busy_o | output | 1 | Cycle in progress |
| rdata_o | output | DATA_W | Last byte read |
| rdata_valid_o | output | 1 | One-cycle pulse on new read byte |
| ready_o | output | 1 | Synchronized device ready status |
| nce_o | output | 1 | Chip enable, active low |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| nwe_o | output | 1 | Write strobe, active low |
| nre_o | output | 1 | Read strobe, active low |
| dq_o | output | DATA_W | Data bus out |
| dq_oe_o | output | 1 | Data bus output enable |
| dq_i | input | DATA_W | Data bus in |
| rnb_i | input | 1 | Device ready/busy line |

## Verification
Two situations are hard to reach from the ports: a configuration write that lands in the middle of a cycle, and a request pulse that arrives while a cycle is running. The bench injects both from inside its tick-counting loop at fixed tick offsets. It then measures the current cycle and the following one. For reads, the bench changes dq_i before the strobe, during the strobe and during the hold phase. This shows that only the byte present at the end of the strobe is captured.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [1:0] {
    OP_CMD  = 2'd0,
    OP_ADDR = 2'd1,
    OP_WR   = 2'd2,
    OP_RD   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;
endpackage

// File: rtl/nand_timing_regs.sv
module nand_timing_regs #(
  parameter int SETUP_W = 2,
  parameter int PULSE_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [SETUP_W-1:0] setup_i,
  input  logic [PULSE_W-1:0] strobe_i,
  input  logic [PULSE_W-1:0] hold_i,
  output logic [SETUP_W-1:0] setup_o,
  output logic [PULSE_W-1:0] strobe_o,
  output logic [PULSE_W-1:0] hold_o
);
  // reset to the slowest timing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      setup_o  <= '1;
      strobe_o <= '1;
      hold_o   <= '1;
    end else if (we_i) begin
      setup_o  <= setup_i;
      strobe_o <= strobe_i;
      hold_o   <= hold_i;
    end
  end
endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], async_i};
  end

  assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nand_seq_pkg::*;
#(
  parameter int SETUP_W = 2,
  parameter int PULSE_W = 3,
  parameter int DATA_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  op_e                op_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [SETUP_W-1:0] setup_i,
  input  logic [PULSE_W-1:0] strobe_i,
  input  logic [PULSE_W-1:0] hold_i,
  input  logic [DATA_W-1:0]  dq_i,
  output phase_e             phase_o,
  output op_e                op_o,
  output logic [DATA_W-1:0]  data_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rvalid_o
);
  localparam int CNT_W = (SETUP_W > PULSE_W) ? SETUP_W : PULSE_W;

  phase_e             phase_q;
  op_e                op_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [PULSE_W-1:0] strobe_q, hold_q;
  logic [DATA_W-1:0]  data_q, rdata_q;
  logic               rvalid_q;
  logic               last_tick;

  assign last_tick = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      op_q     <= OP_CMD;
      cnt_q    <= '0;
      strobe_q <= '0;
      hold_q   <= '0;
      data_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (req_i) begin
          // timing snapshot taken at accept
          phase_q  <= PH_SETUP;
          cnt_q    <= CNT_W'(setup_i);
          strobe_q <= strobe_i;
          hold_q   <= hold_i;
          op_q     <= op_i;
          data_q   <= data_i;
        end
        PH_SETUP: begin
          if (last_tick) begin
            phase_q <= PH_STROBE;
            cnt_q   <= CNT_W'(strobe_q);
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_STROBE: begin
          if (last_tick) begin
            phase_q <= PH_HOLD;
            cnt_q   <= CNT_W'(hold_q);
            if (op_q == OP_RD) begin
              rdata_q  <= dq_i;   // strobe releases at this edge
              rvalid_q <= 1'b1;
            end
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_HOLD: begin
          if (last_tick) phase_q <= PH_IDLE;
          else           cnt_q   <= cnt_q - 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o  = phase_q;
  assign op_o     = op_q;
  assign data_o   = data_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter bit EXT_SETUP = 1'b0,
  parameter int PULSE_W   = 3,
  parameter int DATA_W    = 8,
  parameter int SETUP_W   = EXT_SETUP ? 3 : 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [SETUP_W-1:0] cfg_setup_i,
  input  logic [PULSE_W-1:0] cfg_strobe_i,
  input  logic [PULSE_W-1:0] cfg_hold_i,
  input  logic               ce_we_i,
  input  logic               ce_off_i,
  input  logic               req_i,
  input  logic [1:0]         req_op_i,
  input  logic [DATA_W-1:0]  req_data_i,
  output logic               busy_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rdata_valid_o,
  output logic               ready_o,
  output logic               nce_o,
  output logic               cle_o,
  output logic               ale_o,
  output logic               nwe_o,
  output logic               nre_o,
  output logic [DATA_W-1:0]  dq_o,
  output logic               dq_oe_o,
  input  logic [DATA_W-1:0]  dq_i,
  input  logic               rnb_i
);
  logic [SETUP_W-1:0] setup_w;
  logic [PULSE_W-1:0] strobe_w, hold_w;
  phase_e             phase_w;
  op_e                op_w;
  logic [DATA_W-1:0]  data_w;
  logic               nce_q;
  logic               active, strobing, is_rd;

  nand_timing_regs #(.SETUP_W(SETUP_W), .PULSE_W(PULSE_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .setup_i (cfg_setup_i),
    .strobe_i(cfg_strobe_i),
    .hold_i  (cfg_hold_i),
    .setup_o (setup_w),
    .strobe_o(strobe_w),
    .hold_o  (hold_w)
  );

  nand_phase_seq #(.SETUP_W(SETUP_W), .PULSE_W(PULSE_W), .DATA_W(DATA_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .op_i    (op_e'(req_op_i)),
    .data_i  (req_data_i),
    .setup_i (setup_w),
    .strobe_i(strobe_w),
    .hold_i  (hold_w),
    .dq_i    (dq_i),
    .phase_o (phase_w),
    .op_o    (op_w),
    .data_o  (data_w),
    .rdata_o (rdata_o),
    .rvalid_o(rdata_valid_o)
  );

  nand_rb_sync #(.STAGES(2)) u_rb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(rnb_i),
    .sync_o (ready_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      nce_q <= 1'b1;
    else if (ce_we_i) nce_q <= ce_off_i;
  end

  assign active   = (phase_w != PH_IDLE);
  assign strobing = (phase_w == PH_STROBE);
  assign is_rd    = (op_w == OP_RD);

  assign busy_o  = active;
  assign nce_o   = nce_q;
  assign cle_o   = active && (op_w == OP_CMD);
  assign ale_o   = active && (op_w == OP_ADDR);
  assign nwe_o   = !(strobing && !is_rd);
  assign nre_o   = !(strobing && is_rd);
  assign dq_oe_o = active && !is_rd;
  assign dq_o    = dq_oe_o ? data_w : '0;
endmodule

// File: rtl/nand_cycle_seq_chk.sv
module nand_cycle_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ce_we_i,
  input logic              busy_o,
  input logic              nce_o,
  input logic              cle_o,
  input logic              ale_o,
  input logic              nwe_o,
  input logic              nre_o,
  input logic              dq_oe_o,
  input logic [DATA_W-1:0] dq_o
);
  AST_ONE_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o)); // R4
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nwe_o || nre_o); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (nwe_o && nre_o && !cle_o && !ale_o && !dq_oe_o)); // R1
  AST_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o); // R9
  AST_DATA_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o && $past(dq_oe_o) && $past(busy_o)) |-> $stable(dq_o)); // R5
  AST_CE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_we_i |=> $stable(nce_o)); // R7
endmodule

bind nand_cycle_seq nand_cycle_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .ce_we_i(ce_we_i),
  .busy_o (busy_o),
  .nce_o  (nce_o),
  .cle_o  (cle_o),
  .ale_o  (ale_o),
  .nwe_o  (nwe_o),
  .nre_o  (nre_o),
  .dq_oe_o(dq_oe_o),
  .dq_o   (dq_o)
);

// File: tb/nand_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module nand_cycle_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_setup = '0;
  logic [2:0] cfg_strobe = '0, cfg_hold = '0;
  logic ce_we = 1'b0, ce_off = 1'b0;
  logic req = 1'b0;
  logic [1:0] req_op = '0;
  logic [7:0] req_data = '0;
  logic busy, rvalid, ready, nce, cle, ale, nwe, nre, dq_oe;
  logic [7:0] rdata, dq_o;
  logic [7:0] dq_in = '0;
  logic rnb = 1'b1;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int su, st, ho, cle_n, ale_n, oe_n, dq_bad, nwe_n, nre_n, rv_n, ticks;
  logic [1:0] mid_setup;
  logic [2:0] mid_strobe, mid_hold;

  always #2 clk = ~clk;

  nand_cycle_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_setup_i(cfg_setup), .cfg_strobe_i(cfg_strobe), .cfg_hold_i(cfg_hold),
    .ce_we_i(ce_we), .ce_off_i(ce_off),
    .req_i(req), .req_op_i(req_op), .req_data_i(req_data),
    .busy_o(busy), .rdata_o(rdata), .rdata_valid_o(rvalid), .ready_o(ready),
    .nce_o(nce), .cle_o(cle), .ale_o(ale), .nwe_o(nwe), .nre_o(nre),
    .dq_o(dq_o), .dq_oe_o(dq_oe), .dq_i(dq_in), .rnb_i(rnb)
  );

  task automatic chk(input string req_tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] s, input logic [2:0] p, input logic [2:0] h);
    @(negedge clk);
    cfg_we = 1'b1; cfg_setup = s; cfg_strobe = p; cfg_hold = h;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // poke: 0 none, 1 config write mid-cycle, 2 stray request mid-cycle
  task automatic run_cycle(input logic [1:0] op, input logic [7:0] d,
                           input logic [7:0] rd_val, input int poke);
    su = 0; st = 0; ho = 0; cle_n = 0; ale_n = 0; oe_n = 0; dq_bad = 0;
    nwe_n = 0; nre_n = 0; rv_n = 0; ticks = 0;
    @(negedge clk);
    req = 1'b1; req_op = op; req_data = d;
    @(negedge clk);
    req = 1'b0;
    while (busy && ticks < 100) begin
      ticks++;
      if (cle) cle_n++;
      if (ale) ale_n++;
      if (dq_oe) oe_n++;
      if (dq_oe && dq_o != d) dq_bad++;
      if (!nwe) nwe_n++;
      if (!nre) nre_n++;
      if (rvalid) rv_n++;
      if (!nwe || !nre) begin st++; dq_in = rd_val; end
      else if (st == 0) begin su++; dq_in = ~rd_val; end
      else begin ho++; dq_in = 8'h00; end
      if (poke == 1 && ticks == 1) begin
        cfg_we = 1'b1; cfg_setup = mid_setup; cfg_strobe = mid_strobe; cfg_hold = mid_hold;
      end
      if (poke == 1 && ticks == 2) cfg_we = 1'b0;
      if (poke == 2 && ticks == 3) begin req = 1'b1; req_op = 2'd0; end
      if (poke == 2 && ticks == 4) req = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 nce", nce, 1); chk("R1 cle", cle, 0); chk("R1 ale", ale, 0);
    chk("R1 nwe", nwe, 1); chk("R1 nre", nre, 1); chk("R1 oe", dq_oe, 0);
    chk("R1 busy", busy, 0); chk("R1 ready", ready, 0);
  endtask

  task automatic t_default;
    run_cycle(2'd0, 8'h70, 8'h00, 0);
    chk("R2 setup", su, 4); chk("R2 strobe", st, 8); chk("R2 hold", ho, 8);
    chk("R4 cmd cle", cle_n, 20); chk("R4 cmd ale", ale_n, 0);
    chk("R5 cmd oe", oe_n, 20); chk("R5 cmd data", dq_bad, 0);
    chk("R5 cmd nre", nre_n, 0);
  endtask

  task automatic t_program;
    cfg(2'd0, 3'd0, 3'd0);
    run_cycle(2'd1, 8'h3C, 8'h00, 0);
    chk("R3 min setup", su, 1); chk("R3 min strobe", st, 1); chk("R3 min hold", ho, 1);
    chk("R4 addr ale", ale_n, 3); chk("R4 addr cle", cle_n, 0);
    cfg(2'd2, 3'd5, 3'd1);
    run_cycle(2'd2, 8'hA5, 8'h00, 0);
    chk("R3 setup", su, 3); chk("R3 strobe", st, 6); chk("R3 hold", ho, 2);
    chk("R5 wr oe", oe_n, 11); chk("R5 wr data", dq_bad, 0);
    chk("R5 wr nwe", nwe_n, 6); chk("R5 wr latch", cle_n + ale_n, 0);
  endtask

  task automatic t_read;
    cfg(2'd1, 3'd2, 3'd3);
    run_cycle(2'd3, 8'h00, 8'hC7, 0);
    chk("R6 nre", nre_n, 3); chk("R6 nwe", nwe_n, 0); chk("R6 oe", oe_n, 0);
    chk("R6 setup", su, 2); chk("R6 hold", ho, 4);
    chk("R6 rdata", rdata, 8'hC7); chk("R6 valid", rv_n, 1);
    run_cycle(2'd3, 8'h00, 8'h18, 0);
    chk("R6 rdata2", rdata, 8'h18);
  endtask

  task automatic t_ce;
    @(negedge clk); ce_we = 1'b1; ce_off = 1'b0;
    @(negedge clk); ce_we = 1'b0; ce_off = 1'b1;
    chk("R7 select", nce, 0);
    @(negedge clk);
    chk("R7 held", nce, 0);
    ce_we = 1'b1;
    @(negedge clk); ce_we = 1'b0;
    chk("R7 deselect", nce, 1);
  endtask

  task automatic t_ready;
    @(negedge clk);
    chk("R8 ready idle", ready, 1);
    rnb = 1'b0;
    @(negedge clk);
    chk("R8 one edge", ready, 1);
    @(negedge clk);
    chk("R8 two edges", ready, 0);
    rnb = 1'b1;
    @(negedge clk);
    chk("R8 rise one", ready, 0);
    @(negedge clk);
    chk("R8 rise two", ready, 1);
  endtask

  task automatic t_stray;
    cfg(2'd1, 3'd3, 3'd3);
    run_cycle(2'd2, 8'h11, 8'h00, 2);
    chk("R9 cycle len", ticks, 10);
    chk("R9 stray busy", busy, 0);
    @(negedge clk);
    chk("R9 stray dropped", busy, 0);
    chk("R9 no strobe", nwe, 1);
  endtask

  task automatic t_snapshot;
    cfg(2'd1, 3'd1, 3'd6);
    mid_setup = 2'd0; mid_strobe = 3'd0; mid_hold = 3'd2;
    run_cycle(2'd0, 8'h90, 8'h00, 1);
    chk("R10 old setup", su, 2); chk("R10 old strobe", st, 2); chk("R10 old hold", ho, 7);
    run_cycle(2'd0, 8'h90, 8'h00, 0);
    chk("R10 new setup", su, 1); chk("R10 new strobe", st, 1); chk("R10 new hold", ho, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_default();
    t_program();
    t_read();
    t_ce();
    t_ready();
    t_stray();
    t_snapshot();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule